// File: doc/BRIEF.md
# Register Remap Table Unpacker

This block holds a small array of packed 16-bit register-redirection entries and turns them into two lookup tables: one for integer registers, one for floating-point registers. Software-side logic writes the entries through a group of configuration registers, each carrying XLEN/16 entries. Every accepted write rebuilds both tables. The pipeline can then ask, combinationally, which physical register index and element width an architectural register number is remapped to.

A write to configuration register `k` fills entries `k*XLEN/16` upward and zeroes every entry above the ones it wrote. The write also clears both tables. The block then steps through the entry array one entry per clock. It skips all-zero entries and sends each remaining entry to the integer or floating-point table according to its type bit. The number of entries walked depends on the privilege level in force when the write was accepted. While the walk is running the block reports busy, and lookup results are not to be used.

Top module: `remap_table_unpacker`

## Requirements
- R1: A write with selector `k` stores bits `16*j+15:16*j` of the write data into entry `k*(XLEN/16)+j`, for each `j` from 0 to XLEN/16-1.
- R2: The same write sets every entry with an index above `k*(XLEN/16)+XLEN/16-1` to zero. Entries below `k*(XLEN/16)` keep their value.
- R3: An accepted write clears every row of both tables. After the walk, each table row holds the values of the last walked entry that targeted it, and zero if no walked entry did.
- R4: The walk covers entries 0 to N-1. N is USER_COUNT (default 16) when `priv_mode` was 2'b00 at the accepted write, and PRIV_COUNT (default 4) for any other `priv_mode` value. Entries at N and above have no effect on the tables.
- R5: An entry whose full 16-bit value is zero is skipped and writes no row.
- R6: Entry layout: bits 4:0 are the register key (the table row), bit 5 is the type (1 = integer table, 0 = floating-point table), bits 7:6 are the element width, bits 14:8 are the redirect index, and bit 15 is reserved. A table row stores the redirect index and the element width.
- R7: When several walked entries share the same key and type, the one with the highest index wins.
- R8: `walk_busy` rises on the clock edge that accepts a write and stays high for exactly N cycles. `lookup_ready` is always the inverse of `walk_busy`.
- R9: A write presented while `walk_busy` is high is ignored. It changes neither the entries, nor the tables, nor the walk.
- R10: After synchronous reset, all entries and table rows are zero and `walk_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | SEL_W | Configuration register number within the group |
| cfg_wr_data | input | XLEN | Packed entries to write |
| priv_mode | input | 2 | Privilege level; 2'b00 selects the long walk |
| walk_busy | output | 1 | Rebuild walk in progress |
| lookup_ready | output | 1 | Lookup results are valid |
| int_rd_key | input | 5 | Integer register number to look up |
| int_rd_redir | output | 7 | Redirect index for the integer lookup |
| int_rd_ew | output | 2 | Element width for the integer lookup |
| fp_rd_key | input | 5 | Floating-point register number to look up |
| fp_rd_redir | output | 7 | Redirect index for the floating-point lookup |
| fp_rd_ew | output | 2 | Element width for the floating-point lookup |

## Verification
The assertions assume that XLEN is 32 or 64 and that the walk counts lie between 1 and the entry count. They also assume that `cfg_wr_sel` never names a register beyond the group, so a write always lands inside the entry array. The stimulus keeps to these limits. It draws selectors only from the valid range, and it mixes all four privilege codes, including writes issued in the middle of a walk, so that the ignore rule and both walk lengths are exercised within those limits.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int ENTRY_W = 16;
  localparam int KEY_W   = 5;
  localparam int EW_W    = 2;
  localparam int REDIR_W = 7;
  localparam int ROWS    = 1 << KEY_W;

  typedef struct packed {
    logic               rsvd;
    logic [REDIR_W-1:0] redir;
    logic [EW_W-1:0]    ew;
    logic               is_int;
    logic [KEY_W-1:0]   key;
  } cfg_entry_t;

  typedef struct packed {
    logic [REDIR_W-1:0] redir;
    logic [EW_W-1:0]    ew;
  } row_t;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'b00,
    PRIV_SUPER = 2'b01,
    PRIV_RSVD  = 2'b10,
    PRIV_MACH  = 2'b11
  } priv_e;
endpackage

// File: rtl/remap_entry_store.sv
module remap_entry_store
  import remap_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int NUM_ENTRIES = 16,
  localparam int LANES      = XLEN / ENTRY_W,
  localparam int NUM_CSRS   = NUM_ENTRIES / LANES,
  localparam int SEL_W      = (NUM_CSRS > 1) ? $clog2(NUM_CSRS) : 1,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             hold,
  input  logic [IDX_W-1:0] rd_idx,
  output cfg_entry_t       rd_entry
);

  cfg_entry_t [NUM_ENTRIES-1:0] ent_q;

  // Each entry belongs to one register group and one lane inside it;
  // groups above the written one are wiped on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if ((i / LANES) == int'(wr_sel))
          ent_q[i] <= cfg_entry_t'(wr_data[(i % LANES)*ENTRY_W +: ENTRY_W]);
        else if ((i / LANES) > int'(wr_sel))
          ent_q[i] <= '0;
      end
    end
  end

  assign rd_entry = ent_q[rd_idx];

  AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(ent_q)); // R9

  AST_TOP_ENTRY_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (int'(wr_sel) < NUM_CSRS-1)) |=> (ent_q[NUM_ENTRIES-1] == '0)); // R2

endmodule

// File: rtl/remap_walker.sv
module remap_walker
  import remap_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int USER_COUNT  = 16,
  parameter int PRIV_COUNT  = 4,
  localparam int CNT_W      = $clog2(NUM_ENTRIES + 1),
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       priv_mode,
  input  cfg_entry_t       entry,
  output logic             busy,
  output logic [IDX_W-1:0] ptr,
  output logic             upd_int,
  output logic             upd_fp,
  output logic [KEY_W-1:0] upd_key,
  output row_t             upd_row
);

  logic             busy_q;
  logic [IDX_W-1:0] ptr_q;
  logic [CNT_W-1:0] limit_q;
  logic             last;
  logic             occupied;

  assign last = ((CNT_W'(ptr_q) + CNT_W'(1)) == limit_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      ptr_q   <= '0;
      limit_q <= '0;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      ptr_q   <= '0;
      limit_q <= (priv_e'(priv_mode) == PRIV_USER) ? CNT_W'(USER_COUNT)
                                                    : CNT_W'(PRIV_COUNT);
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      else      ptr_q  <= ptr_q + IDX_W'(1);
    end
  end

  assign occupied = (entry != '0);
  assign upd_int  = busy_q && occupied && entry.is_int;
  assign upd_fp   = busy_q && occupied && !entry.is_int;
  assign upd_key  = entry.key;
  assign upd_row  = '{redir: entry.redir, ew: entry.ew};
  assign busy     = busy_q;
  assign ptr      = ptr_q;

  AST_WALK_ENDS: assert property (@(posedge clk) disable iff (rst)
    (busy_q && last) |=> !busy_q); // R8

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last) |=> (busy_q && ptr_q == $past(ptr_q) + IDX_W'(1))); // R4

endmodule

// File: rtl/remap_lookup_table.sv
module remap_lookup_table
  import remap_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  input  row_t             wr_row,
  input  logic [KEY_W-1:0] rd_key,
  output row_t             rd_row
);

  row_t mem [ROWS];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else if (wr_en) begin
      mem[wr_key] <= wr_row;
    end
  end

  assign rd_row = mem[rd_key];

  AST_NO_WR_ON_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clear |-> !wr_en); // R3

endmodule

// File: rtl/remap_table_unpacker.sv
module remap_table_unpacker
  import remap_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int NUM_ENTRIES = 16,
  parameter int USER_COUNT  = 16,
  parameter int PRIV_COUNT  = 4,
  localparam int LANES      = XLEN / ENTRY_W,
  localparam int NUM_CSRS   = NUM_ENTRIES / LANES,
  localparam int SEL_W      = (NUM_CSRS > 1) ? $clog2(NUM_CSRS) : 1,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr_en,
  input  logic [SEL_W-1:0]   cfg_wr_sel,
  input  logic [XLEN-1:0]    cfg_wr_data,
  input  logic [1:0]         priv_mode,
  output logic               walk_busy,
  output logic               lookup_ready,
  input  logic [KEY_W-1:0]   int_rd_key,
  output logic [REDIR_W-1:0] int_rd_redir,
  output logic [EW_W-1:0]    int_rd_ew,
  input  logic [KEY_W-1:0]   fp_rd_key,
  output logic [REDIR_W-1:0] fp_rd_redir,
  output logic [EW_W-1:0]    fp_rd_ew
);

  logic             wr_accept;
  logic [IDX_W-1:0] walk_ptr;
  cfg_entry_t       walk_entry;
  logic             upd_int;
  logic             upd_fp;
  logic [KEY_W-1:0] upd_key;
  row_t             upd_row;
  logic             tab_wr  [2];
  logic [KEY_W-1:0] tab_key [2];
  row_t             tab_rd  [2];

  assign wr_accept = cfg_wr_en && !walk_busy;

  remap_entry_store #(.XLEN(XLEN), .NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_accept),
    .wr_sel   (cfg_wr_sel),
    .wr_data  (cfg_wr_data),
    .hold     (walk_busy),
    .rd_idx   (walk_ptr),
    .rd_entry (walk_entry)
  );

  remap_walker #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .USER_COUNT  (USER_COUNT),
    .PRIV_COUNT  (PRIV_COUNT)
  ) u_walker (
    .clk       (clk),
    .rst       (rst),
    .start     (wr_accept),
    .priv_mode (priv_mode),
    .entry     (walk_entry),
    .busy      (walk_busy),
    .ptr       (walk_ptr),
    .upd_int   (upd_int),
    .upd_fp    (upd_fp),
    .upd_key   (upd_key),
    .upd_row   (upd_row)
  );

  assign tab_wr[0]  = upd_int;
  assign tab_wr[1]  = upd_fp;
  assign tab_key[0] = int_rd_key;
  assign tab_key[1] = fp_rd_key;

  // Table 0 serves integer registers, table 1 floating-point registers.
  for (genvar t = 0; t < 2; t++) begin : g_tab
    remap_lookup_table u_tab (
      .clk    (clk),
      .rst    (rst),
      .clear  (wr_accept),
      .wr_en  (tab_wr[t]),
      .wr_key (upd_key),
      .wr_row (upd_row),
      .rd_key (tab_key[t]),
      .rd_row (tab_rd[t])
    );
  end

  assign int_rd_redir = tab_rd[0].redir;
  assign int_rd_ew    = tab_rd[0].ew;
  assign fp_rd_redir  = tab_rd[1].redir;
  assign fp_rd_ew     = tab_rd[1].ew;
  assign lookup_ready = !walk_busy;

  AST_BUSY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(walk_busy) |-> $past(cfg_wr_en)); // R8

  AST_BOTH_TABLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !walk_busy |-> !(tab_wr[0] || tab_wr[1])); // R5

endmodule

// File: tb/test_remap_table_unpacker.sv
module test_remap_table_unpacker;
  localparam int XLEN  = 32;
  localparam int NE    = 16;
  localparam int LANES = XLEN / 16;
  localparam int NCSR  = NE / LANES;
  localparam int SEL_W = $clog2(NCSR);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [SEL_W-1:0] wr_sel = '0;
  logic [XLEN-1:0]  wr_data = '0;
  logic [1:0]       priv = 2'b00;
  logic             busy, ready;
  logic [4:0]       ik = '0, fk = '0;
  logic [6:0]       ir, fr;
  logic [1:0]       iw, fw;

  always #4 clk = ~clk;

  remap_table_unpacker #(.XLEN(XLEN), .NUM_ENTRIES(NE)) i_remap_table_unpacker (
    .clk(clk), .rst(rst), .cfg_wr_en(wr_en), .cfg_wr_sel(wr_sel),
    .cfg_wr_data(wr_data), .priv_mode(priv), .walk_busy(busy),
    .lookup_ready(ready), .int_rd_key(ik), .int_rd_redir(ir), .int_rd_ew(iw),
    .fp_rd_key(fk), .fp_rd_redir(fr), .fp_rd_ew(fw)
  );

  // Behavioural reference model
  int unsigned m_ent [NE];
  int m_ir [32], m_iw [32], m_fr [32], m_fw [32];
  bit mbusy;
  int mptr, mlim;
  int unsigned ev;
  int kv;

  int tests = 0, fails = 0;
  bit done = 0;
  string cur_req = "R10";

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_ent[i]) m_ent[i] = 0;
      for (int r = 0; r < 32; r++) begin m_ir[r]=0; m_iw[r]=0; m_fr[r]=0; m_fw[r]=0; end
      mbusy = 0;
    end else if (mbusy) begin
      ev = m_ent[mptr];
      if (ev != 0) begin
        kv = int'(ev & 31);
        if (((ev >> 5) & 1) == 1) begin
          m_ir[kv] = int'((ev >> 8) & 127); m_iw[kv] = int'((ev >> 6) & 3);
        end else begin
          m_fr[kv] = int'((ev >> 8) & 127); m_fw[kv] = int'((ev >> 6) & 3);
        end
      end
      if (mptr == mlim - 1) mbusy = 0;
      else mptr++;
    end else if (wr_en) begin
      for (int l = 0; l < LANES; l++)
        m_ent[int'(wr_sel)*LANES + l] = int'((wr_data >> (16*l)) & 32'hFFFF);
      for (int e = (int'(wr_sel)+1)*LANES; e < NE; e++) m_ent[e] = 0;
      for (int r = 0; r < 32; r++) begin m_ir[r]=0; m_iw[r]=0; m_fr[r]=0; m_fw[r]=0; end
      mlim = (priv == 2'b00) ? 16 : 4;
      mptr = 0;
      mbusy = 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      tests++;
      if (busy !== mbusy) begin
        fails++;
        $display("FAIL %s R8 walk_busy got %0d exp %0d", cur_req, busy, mbusy);
      end
      tests++;
      if (ready !== !mbusy) begin
        fails++;
        $display("FAIL %s R8 lookup_ready got %0d exp %0d", cur_req, ready, !mbusy);
      end
      if (!mbusy) begin
        tests++;
        if (ir !== 7'(m_ir[ik]) || iw !== 2'(m_iw[ik])) begin
          fails++;
          $display("FAIL %s int row %0d got %0d/%0d exp %0d/%0d",
                   cur_req, ik, ir, iw, m_ir[ik], m_iw[ik]);
        end
        tests++;
        if (fr !== 7'(m_fr[fk]) || fw !== 2'(m_fw[fk])) begin
          fails++;
          $display("FAIL %s fp row %0d got %0d/%0d exp %0d/%0d",
                   cur_req, fk, fr, fw, m_fr[fk], m_fw[fk]);
        end
      end
      ik = ik + 5'd1;
      fk = fk + 5'd3;
    end
  end

  function automatic logic [15:0] mk(int key, int ti, int ew, int rd);
    return 16'((rd << 8) | (ew << 6) | (ti << 5) | key);
  endfunction

  task automatic wr(input int sel, input logic [31:0] d, input logic [1:0] p);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = SEL_W'(sel); wr_data = d; priv = p;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (40) @(posedge clk);

    cur_req = "R1";
    wr(0, {mk(7,0,1,18), mk(3,1,2,69)}, 2'b00); settle();
    wr(5, {mk(9,1,3,100), mk(9,0,0,33)}, 2'b00); settle();

    cur_req = "R2";
    wr(6, {mk(1,1,1,11), mk(2,0,2,22)}, 2'b00); settle();
    wr(1, {mk(4,1,1,44), mk(4,0,3,55)}, 2'b00); settle();

    cur_req = "R4";
    wr(0, {mk(6,1,1,61), mk(8,0,2,82)}, 2'b00); settle();
    wr(2, {mk(6,1,3,99), mk(8,0,1,98)}, 2'b11); settle();
    wr(2, {mk(6,1,3,99), mk(8,0,1,98)}, 2'b01); settle();
    wr(2, {mk(6,1,3,99), mk(8,0,1,98)}, 2'b00); settle();

    cur_req = "R5";
    wr(0, {16'h0000, mk(0,0,3,51)}, 2'b00); settle();

    cur_req = "R6";
    wr(0, {mk(31,0,2,127), mk(31,1,1,1)}, 2'b00); settle();
    wr(0, {16'h8000 | mk(12,1,0,0), 16'hFFFF}, 2'b10); settle();

    cur_req = "R7";
    wr(0, {mk(10,1,1,20), mk(10,1,2,30)}, 2'b00); settle();

    cur_req = "R9";
    wr(0, {mk(2,1,1,5), mk(3,0,2,6)}, 2'b00);
    wr(0, {mk(2,1,3,77), mk(3,0,3,78)}, 2'b00); settle();

    cur_req = "R3";
    for (int n = 0; n < 150; n++) begin
      wr(int'($urandom_range(NCSR-1)), $urandom, 2'($urandom_range(3)));
      repeat ($urandom_range(20)) @(posedge clk);
    end
    settle();

    cur_req = "R10";
    @(posedge clk); #1 rst = 1'b1;
    repeat (3) @(posedge clk); #1 rst = 1'b0;
    repeat (40) @(posedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 60000);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog got hang exp completion");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule